// File: doc/BRIEF.md
# 8-bit Accumulator ALU

This block is the arithmetic and logic stage of an accumulator-based microcontroller datapath. Each cycle it takes the accumulator byte, a source operand byte, the B register byte, the incoming carry, auxiliary-carry and overflow flags, and a 5-bit operation select. It produces a result byte, a second byte that feeds B, and the updated carry, auxiliary-carry and overflow flags.

The operations are add, add with carry, subtract with borrow, increment, decrement, multiply, divide, BCD decimal adjust, AND, OR, XOR, clear, complement, nibble swap, and four rotates. Two of the rotates pass through carry. All outputs are registered, so a result appears one clock after its inputs. Fetching operands and writing results back to registers are handled by the surrounding datapath.

Top module: `alu8_core`

## Requirements
- R1: All outputs come from registers. Inputs sampled at a rising clock edge show on the outputs right after that edge. While rst_ni is low, every output is zero.
- R2: op_i codes are: 0 add, 1 add-with-carry, 2 subtract-with-borrow, 3 increment, 4 decrement, 5 multiply, 6 divide, 7 decimal adjust, 8 AND, 9 OR, 10 XOR, 11 clear, 12 complement, 13 nibble swap, 14 rotate left, 15 rotate left through carry, 16 rotate right, 17 rotate right through carry. Codes 18 to 31 return the accumulator, B and all three flags unchanged.
- R3: Add returns acc+src, and add-with-carry returns acc+src+cy_i, both modulo 256. cy_o is the carry out of bit 7 and ac_o is the carry out of bit 3. ov_o is set when both operands have the same sign bit and the result's sign bit differs from it.
- R4: Subtract-with-borrow always returns acc−src−cy_i modulo 256. cy_o is the borrow out of bit 7 and ac_o is the borrow out of bit 3. ov_o is set when the operands' sign bits differ and the result's sign bit differs from the accumulator's.
- R5: Increment and decrement return acc+1 and acc−1, wrapping at the byte boundary. All three flags are left unchanged.
- R6: Multiply places acc×B with the low byte on res_o and the high byte on hi_o. It clears cy_o, sets ov_o exactly when the product exceeds 255, and leaves ac_o unchanged.
- R7: Divide with a nonzero B returns the quotient on res_o and the remainder on hi_o. It clears cy_o and ov_o, and leaves ac_o unchanged.
- R8: Divide with B equal to zero sets ov_o, clears cy_o and leaves ac_o unchanged. res_o and hi_o are not specified in this case.
- R9: Decimal adjust works in two steps. First, it adds 06h when the low nibble exceeds 9 or ac_i is set; a carry out of bit 7 from this step counts as carry. Second, it adds 60h when the resulting high nibble exceeds 9 or carry is set. cy_o is 1 exactly when the second step is applied. ac_o and ov_o are unchanged.
- R10: AND, OR and XOR combine acc with src bit by bit. Clear returns 00h and complement returns ~acc. All three flags are unchanged.
- R11: Nibble swap exchanges acc[7:4] with acc[3:0]. Rotate left moves bit 7 into bit 0, and rotate right moves bit 0 into bit 7. The flags are unchanged.
- R12: Rotate left through carry returns {acc[6:0], cy_i} with cy_o = acc[7]. Rotate right through carry returns {cy_i, acc[7:1]} with cy_o = acc[0]. ac_o and ov_o are unchanged.
- R13: For every operation other than multiply and divide, hi_o equals b_i. ac_o equals ac_i for every operation except codes 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation select |
| acc_i | input | 8 | Accumulator operand |
| src_i | input | 8 | Source operand |
| b_i | input | 8 | B register operand |
| cy_i | input | 1 | Incoming carry / borrow |
| ac_i | input | 1 | Incoming auxiliary carry |
| ov_i | input | 1 | Incoming overflow |
| res_o | output | 8 | Result byte (accumulator) |
| hi_o | output | 8 | Second result byte (B register) |
| cy_o | output | 1 | Updated carry |
| ac_o | output | 1 | Updated auxiliary carry |
| ov_o | output | 1 | Updated overflow |

## Verification
Two things can happen in a single operation: the nibble carry and the byte carry in the adder, and the low-nibble and high-nibble corrections in decimal adjust. Directed cases provoke both pairs at once. Examples are 0Fh+F1h for carries out of bit 3 and bit 7 together, 7Fh+01h for auxiliary carry together with signed overflow, and a decimal adjust of 9Ah, which applies both corrections and wraps to 00h with carry set. The bench judges each case by the full flag tuple from its own model. Random operands over all 32 codes, with occasional zero divisors, then exercise the same interactions broadly.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NIB_W  = DATA_W / 2;
  localparam int unsigned OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUBB = 5'd2,  OP_INC  = 5'd3,
    OP_DEC  = 5'd4,  OP_MUL  = 5'd5,  OP_DIV  = 5'd6,  OP_DADJ = 5'd7,
    OP_AND  = 5'd8,  OP_OR   = 5'd9,  OP_XOR  = 5'd10, OP_CLR  = 5'd11,
    OP_CPL  = 5'd12, OP_SWAP = 5'd13, OP_RL   = 5'd14, OP_RLC  = 5'd15,
    OP_RR   = 5'd16, OP_RRC  = 5'd17
  } alu_op_e;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic [DATA_W-1:0] hi;
    logic              cy;
    logic              ac;
    logic              ov;
  } alu_out_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] s_i,
  input  logic              cin_i,
  input  logic              sub_i,
  input  logic              use_c_i,
  output logic [DATA_W-1:0] r_o,
  output logic              cy_o,
  output logic              ac_o,
  output logic              ov_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] x;
  logic              ci;
  logic [DATA_W:0]   sum;
  logic [NIB_W:0]    lo;

  // subtract as a + ~s + ~borrow; flags invert back on the way out
  always_comb begin
    x    = sub_i ? ~s_i : s_i;
    ci   = sub_i ? ~cin_i : (use_c_i & cin_i);
    sum  = {1'b0, a_i} + {1'b0, x} + {{DATA_W{1'b0}}, ci};
    lo   = {1'b0, a_i[NIB_W-1:0]} + {1'b0, x[NIB_W-1:0]} + {{NIB_W{1'b0}}, ci};
    r_o  = sum[DATA_W-1:0];
    cy_o = sum[DATA_W] ^ sub_i;
    ac_o = lo[NIB_W] ^ sub_i;
    ov_o = (a_i[MSB] == x[MSB]) && (sum[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv
  import alu8_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] prod_lo_o,
  output logic [DATA_W-1:0] prod_hi_o,
  output logic              mul_ov_o,
  output logic [DATA_W-1:0] quo_o,
  output logic [DATA_W-1:0] rem_o,
  output logic              div_zero_o
);
  localparam int unsigned PW = 2 * DATA_W;

  logic [PW-1:0] prod;

  always_comb begin
    prod       = {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i};
    prod_lo_o  = prod[DATA_W-1:0];
    prod_hi_o  = prod[PW-1:DATA_W];
    mul_ov_o   = |prod[PW-1:DATA_W];
    div_zero_o = (b_i == '0);
    quo_o      = div_zero_o ? '1  : a_i / b_i;
    rem_o      = div_zero_o ? a_i : a_i % b_i;
  end
endmodule

// File: rtl/alu8_dadj.sv
module alu8_dadj
  import alu8_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic              cy_i,
  input  logic              ac_i,
  output logic [DATA_W-1:0] r_o,
  output logic              cy_o
);
  localparam logic [NIB_W-1:0]  NIB_MAX = NIB_W'(9);
  localparam logic [DATA_W:0]   LO_ADJ  = (DATA_W+1)'(6);
  localparam logic [DATA_W:0]   HI_ADJ  = LO_ADJ << NIB_W;

  logic [DATA_W:0] t1, t2;
  logic            lo_fix, hi_fix, c1;

  always_comb begin
    lo_fix = (a_i[NIB_W-1:0] > NIB_MAX) | ac_i;
    t1     = {1'b0, a_i} + (lo_fix ? LO_ADJ : '0);
    c1     = cy_i | t1[DATA_W];
    hi_fix = (t1[DATA_W-1:NIB_W] > NIB_MAX) | c1;
    t2     = t1 + (hi_fix ? HI_ADJ : '0);
    r_o    = t2[DATA_W-1:0];
    cy_o   = hi_fix;
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] s_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] r_o,
  output logic              cy_o
);
  localparam int unsigned MSB = DATA_W - 1;

  always_comb begin
    r_o  = a_i;
    cy_o = cy_i;
    case (op_i)
      OP_AND:  r_o = a_i & s_i;
      OP_OR:   r_o = a_i | s_i;
      OP_XOR:  r_o = a_i ^ s_i;
      OP_CLR:  r_o = '0;
      OP_CPL:  r_o = ~a_i;
      OP_SWAP: r_o = {a_i[NIB_W-1:0], a_i[DATA_W-1:NIB_W]};
      OP_RL:   r_o = {a_i[MSB-1:0], a_i[MSB]};
      OP_RR:   r_o = {a_i[0], a_i[MSB:1]};
      OP_RLC: begin
        r_o  = {a_i[MSB-1:0], cy_i};
        cy_o = a_i[MSB];
      end
      OP_RRC: begin
        r_o  = {cy_i, a_i[MSB:1]};
        cy_o = a_i[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cy_i,
  input  logic              ac_i,
  input  logic              ov_i,
  output logic [DATA_W-1:0] res_o,
  output logic [DATA_W-1:0] hi_o,
  output logic              cy_o,
  output logic              ac_o,
  output logic              ov_o
);
  localparam int unsigned PW = 2 * DATA_W;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  alu_op_e  op;
  alu_out_t nxt, q;

  logic [DATA_W-1:0] as_r, mul_lo, mul_hi, quo, rem, da_r, lg_r;
  logic              as_cy, as_ac, as_ov, mul_ov, div_zero, da_cy, lg_cy;
  logic              is_sub, is_carry_add;

  assign op           = alu_op_e'(op_i);
  assign is_sub       = (op == OP_SUBB);
  assign is_carry_add = (op == OP_ADDC);

  alu8_addsub u_addsub (
    .a_i(acc_i), .s_i(src_i), .cin_i(cy_i), .sub_i(is_sub), .use_c_i(is_carry_add),
    .r_o(as_r), .cy_o(as_cy), .ac_o(as_ac), .ov_o(as_ov)
  );

  alu8_muldiv u_muldiv (
    .a_i(acc_i), .b_i(b_i), .prod_lo_o(mul_lo), .prod_hi_o(mul_hi), .mul_ov_o(mul_ov),
    .quo_o(quo), .rem_o(rem), .div_zero_o(div_zero)
  );

  alu8_dadj u_dadj (
    .a_i(acc_i), .cy_i(cy_i), .ac_i(ac_i), .r_o(da_r), .cy_o(da_cy)
  );

  alu8_logic u_logic (
    .op_i(op), .a_i(acc_i), .s_i(src_i), .cy_i(cy_i), .r_o(lg_r), .cy_o(lg_cy)
  );

  always_comb begin
    nxt = '{res: acc_i, hi: b_i, cy: cy_i, ac: ac_i, ov: ov_i};
    case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        nxt.res = as_r;
        nxt.cy  = as_cy;
        nxt.ac  = as_ac;
        nxt.ov  = as_ov;
      end
      OP_INC:  nxt.res = acc_i + ONE;
      OP_DEC:  nxt.res = acc_i - ONE;
      OP_MUL: begin
        nxt.res = mul_lo;
        nxt.hi  = mul_hi;
        nxt.cy  = 1'b0;
        nxt.ov  = mul_ov;
      end
      OP_DIV: begin
        nxt.res = quo;
        nxt.hi  = rem;
        nxt.cy  = 1'b0;
        nxt.ov  = div_zero;
      end
      OP_DADJ: begin
        nxt.res = da_r;
        nxt.cy  = da_cy;
      end
      OP_AND, OP_OR, OP_XOR, OP_CLR, OP_CPL, OP_SWAP,
      OP_RL, OP_RLC, OP_RR, OP_RRC: begin
        nxt.res = lg_r;
        nxt.cy  = lg_cy;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign res_o = q.res;
  assign hi_o  = q.hi;
  assign cy_o  = q.cy;
  assign ac_o  = q.ac;
  assign ov_o  = q.ov;

  // one registered cycle must pass before $past refers to post-reset inputs
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R3
  add_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(op_i) == OP_ADD) |->
      ({cy_o, res_o} == {1'b0, $past(acc_i)} + {1'b0, $past(src_i)}));

  // R5
  incdec_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC)) |->
      (cy_o == $past(cy_i) && ac_o == $past(ac_i) && ov_o == $past(ov_i)));

  // R6
  mul_prod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(op_i) == OP_MUL) |->
      ({hi_o, res_o} == PW'($past(acc_i)) * PW'($past(b_i)) && !cy_o &&
       ov_o == (hi_o != '0)));

  // R7
  div_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(op_i) == OP_DIV && $past(b_i) != '0) |->
      (PW'(res_o) * PW'($past(b_i)) + PW'(hi_o) == PW'($past(acc_i)) &&
       hi_o < $past(b_i) && !cy_o && !ov_o));

  // R8
  div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(op_i) == OP_DIV && $past(b_i) == '0) |-> (ov_o && !cy_o));

  // R11
  swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(op_i) == OP_SWAP) |->
      (res_o == {$past(acc_i[NIB_W-1:0]), $past(acc_i[DATA_W-1:NIB_W])}));

  // R13
  hi_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(op_i) != OP_MUL && $past(op_i) != OP_DIV) |->
      (hi_o == $past(b_i)));
endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] acc_i = '0, src_i = '0, b_i = '0;
  logic       cy_i = 1'b0, ac_i = 1'b0, ov_i = 1'b0;
  logic [7:0] res_o, hi_o;
  logic       cy_o, ac_o, ov_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  alu8_core uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .acc_i(acc_i), .src_i(src_i),
    .b_i(b_i), .cy_i(cy_i), .ac_i(ac_i), .ov_i(ov_i),
    .res_o(res_o), .hi_o(hi_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o)
  );

  // expected {res, hi, cy, ac, ov}
  function automatic logic [20:0] model(logic [4:0] op, logic [7:0] a, logic [7:0] s,
                                        logic [7:0] b, logic c, logic ac, logic ov);
    logic [7:0] r, h;
    logic nc, nac, nov, c1;
    int x, p, cin;
    r = a; h = b; nc = c; nac = ac; nov = ov;
    case (op)
      5'd0, 5'd1: begin
        cin = (op == 5'd1) ? int'(c) : 0;
        x   = int'(a) + int'(s) + cin;
        r   = x[7:0];
        nc  = x > 255;
        nac = (int'(a[3:0]) + int'(s[3:0]) + cin) > 15;
        nov = (a[7] == s[7]) && (r[7] != a[7]);
      end
      5'd2: begin
        x   = int'(a) - int'(s) - int'(c);
        r   = x[7:0];
        nc  = x < 0;
        nac = (int'(a[3:0]) - int'(s[3:0]) - int'(c)) < 0;
        nov = (a[7] != s[7]) && (r[7] != a[7]);
      end
      5'd3: r = a + 8'd1;
      5'd4: r = a - 8'd1;
      5'd5: begin
        p = int'(a) * int'(b);
        r = p[7:0]; h = p[15:8]; nc = 1'b0; nov = p > 255;
      end
      5'd6: begin
        nc = 1'b0;
        if (b == 8'd0) nov = 1'b1;
        else begin r = a / b; h = a % b; nov = 1'b0; end
      end
      5'd7: begin
        x = int'(a);
        if (a[3:0] > 4'd9 || ac) x = x + 6;
        c1 = c || (x > 255);
        if (x[7:4] > 4'd9 || c1) begin x = x + 96; nc = 1'b1; end
        else nc = 1'b0;
        r = x[7:0];
      end
      5'd8:  r = a & s;
      5'd9:  r = a | s;
      5'd10: r = a ^ s;
      5'd11: r = 8'h00;
      5'd12: r = ~a;
      5'd13: r = {a[3:0], a[7:4]};
      5'd14: r = {a[6:0], a[7]};
      5'd15: begin r = {a[6:0], c}; nc = a[7]; end
      5'd16: r = {a[0], a[7:1]};
      5'd17: begin r = {c, a[7:1]}; nc = a[0]; end
      default: ;
    endcase
    return {r, h, nc, nac, nov};
  endfunction

  function automatic string req_of(logic [4:0] op, logic [7:0] b);
    case (op)
      5'd0, 5'd1:                  return "R3";
      5'd2:                        return "R4";
      5'd3, 5'd4:                  return "R5";
      5'd5:                        return "R6";
      5'd6:                        return (b == 8'd0) ? "R8" : "R7";
      5'd7:                        return "R9";
      5'd8, 5'd9, 5'd10, 5'd11, 5'd12: return "R10";
      5'd13, 5'd14, 5'd16:         return "R11";
      5'd15, 5'd17:                return "R12";
      default:                     return "R2";
    endcase
  endfunction

  task automatic check(string req, logic [20:0] got, logic [20:0] exp, logic [20:0] mask);
    n_chk++;
    if ((got & mask) !== (exp & mask)) begin
      n_fail++;
      $display("FAIL %s: got res=%h hi=%h cy=%b ac=%b ov=%b, expected res=%h hi=%h cy=%b ac=%b ov=%b",
               req, got[20:13], got[12:5], got[2], got[1], got[0],
               exp[20:13], exp[12:5], exp[2], exp[1], exp[0]);
    end
  endtask

  // called at a falling edge; result is sampled at the next falling edge
  task automatic run_op(logic [4:0] op, logic [7:0] a, logic [7:0] s, logic [7:0] b,
                        logic c, logic ac, logic ov, string req);
    logic [20:0] exp, mask;
    op_i = op; acc_i = a; src_i = s; b_i = b; cy_i = c; ac_i = ac; ov_i = ov;
    exp  = model(op, a, s, b, c, ac, ov);
    mask = (op == 5'd6 && b == 8'd0) ? 21'h7 : 21'h1F_FFFF;
    @(negedge clk_i);
    check(req, {res_o, hi_o, cy_o, ac_o, ov_o}, exp, mask);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
    end
  end

  initial begin
    int unsigned seed_dummy;
    logic [4:0] rop;
    logic [7:0] rb;
    seed_dummy = $urandom(32'd51423);
    op_i = 5'd0; acc_i = 8'hA5; src_i = 8'h5A; b_i = 8'h33;
    cy_i = 1'b1; ac_i = 1'b1; ov_i = 1'b1;
    repeat (3) @(negedge clk_i);
    // R1: outputs held at zero during reset
    check("R1", {res_o, hi_o, cy_o, ac_o, ov_o}, 21'h0, 21'h1F_FFFF);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3: nibble and byte carry together, overflow with aux carry
    run_op(5'd0, 8'h0F, 8'hF1, 8'h11, 1'b1, 1'b0, 1'b0, "R3");
    run_op(5'd0, 8'h7F, 8'h01, 8'h11, 1'b0, 1'b0, 1'b0, "R3");
    run_op(5'd1, 8'hFF, 8'h00, 8'h11, 1'b1, 1'b0, 1'b0, "R3");
    // R4: borrow and signed overflow
    run_op(5'd2, 8'h00, 8'h00, 8'h11, 1'b1, 1'b0, 1'b0, "R4");
    run_op(5'd2, 8'h80, 8'h01, 8'h11, 1'b0, 1'b0, 1'b0, "R4");
    // R5: wrap, flags untouched
    run_op(5'd3, 8'hFF, 8'h00, 8'h11, 1'b1, 1'b1, 1'b0, "R5");
    run_op(5'd4, 8'h00, 8'h00, 8'h11, 1'b0, 1'b0, 1'b1, "R5");
    // R6: largest product and the 256 boundary
    run_op(5'd5, 8'hFF, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, "R6");
    run_op(5'd5, 8'h10, 8'h00, 8'h10, 1'b1, 1'b0, 1'b0, "R6");
    run_op(5'd5, 8'h0F, 8'h00, 8'h11, 1'b0, 1'b0, 1'b1, "R6");
    // R7 / R8
    run_op(5'd6, 8'd251, 8'h00, 8'd18, 1'b1, 1'b1, 1'b1, "R7");
    run_op(5'd6, 8'h42, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, "R8");
    // R9: both corrections in one go, and aux-carry driven correction
    run_op(5'd7, 8'h9A, 8'h00, 8'h11, 1'b0, 1'b0, 1'b0, "R9");
    run_op(5'd7, 8'h13, 8'h00, 8'h11, 1'b0, 1'b1, 1'b0, "R9");
    run_op(5'd7, 8'hFF, 8'h00, 8'h11, 1'b0, 1'b1, 1'b1, "R9");
    // R12: rotates through carry
    run_op(5'd15, 8'h80, 8'h00, 8'h11, 1'b1, 1'b0, 1'b0, "R12");
    run_op(5'd17, 8'h01, 8'h00, 8'h11, 1'b0, 1'b0, 1'b0, "R12");
    // R11
    run_op(5'd13, 8'h3C, 8'h00, 8'h11, 1'b1, 1'b0, 1'b1, "R11");
    // R13: B passes through and aux carry untouched on logic op
    run_op(5'd8, 8'hF0, 8'h3C, 8'h5A, 1'b0, 1'b1, 1'b0, "R13");
    // R2: unused code is a no-op
    run_op(5'd25, 8'hC3, 8'h3C, 8'h77, 1'b1, 1'b0, 1'b1, "R2");

    for (int i = 0; i < 3000; i++) begin
      rop = 5'($urandom % 32);
      rb  = 8'($urandom);
      if (rop == 5'd6 && ($urandom % 8) == 0) rb = 8'h00;
      run_op(rop, 8'($urandom), 8'($urandom), rb,
             1'($urandom), 1'($urandom), 1'($urandom), req_of(rop, rb));
    end

    done = 1'b1;
    finish_run();
  end
endmodule